// File: doc/BRIEF.md
# Cell Header Virtual-Circuit Filter and Table Addresser

This block sits on the receive side of a cell switch. It takes the path identifier (8 bits) and the channel identifier (16 bits) of each incoming cell header over a valid/ready handshake. It then decides whether the cell passes a header filter. The path identifier is compared bit by bit under a mask. The channel identifier must equal a programmed value exactly.

For a passing cell, the block forms a 21-bit byte address into a virtual-circuit lookup table of 32-bit entries. It builds a 15-bit entry index from a programmable number of low channel bits, with the low path bits placed directly above them. Any bits above those are zero. The index is scaled by four and added to a programmable table base.

A small configuration register file holds these settings and can be read back. The bit counts, the path match and mask, the channel match and the base address live there. The result leaves through an output register that is held under backpressure.

Top module: `cell_vc_filter`

## Requirements
- R1: After reset every configuration register reads 0000h, `out_valid` is 0 and `in_ready` is 1.
- R2: The register map is as follows. Index 0 is the join-count register: channel bit count in bits 4:0, path bit count in bits 7:5, a stored spare bit in bit 8, and bits 15:9 reading 0. Index 1 is the path match and index 2 the path mask; both use bits 7:0 and read 0 in bits 15:8. Index 3 is the channel match (16 bits). Index 4 holds table base bits 15:0. Index 5 holds table base bits 20:16 in bits 4:0 and reads 0 above. Indices 6 and 7 read 0.
- R3: The 15-bit entry index holds the low N channel bits in bits N-1:0 and the low M path bits in bits N+M-1:N, with zeros above. For N=8, M=4, path 23h and channel 5678h the index is 0378h.
- R4: For a passing cell, `out_addr` equals (base + 4 × index) modulo 2^21. The worked case above with base 0 gives 00DE0h.
- R5: Where a path mask bit is 1, that path bit must equal the matching bit of the path match value. Where it is 0, that bit always counts as matching.
- R6: The channel identifier must equal the channel match register in all 16 bits for the cell to pass.
- R7: A cell passes only when both the path check and the channel check succeed. A discarded cell is reported with `out_pass`=0 and `out_addr`=0.
- R8: `cfg_err` is 1 whenever N+M is below 8 or above 15. While it is 1, every cell is discarded.
- R9: A header accepted on a clock edge (`in_valid` and `in_ready` both 1) appears on the outputs with `out_valid`=1 right after that same edge.
- R10: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_pass` and `out_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Read data of the indexed register (combinational) |
| cfg_err | output | 1 | Bit counts outside the legal sum range |
| in_valid | input | 1 | Header present |
| in_ready | output | 1 | Header can be taken |
| in_vpi | input | 8 | Path identifier of the cell |
| in_vci | input | 16 | Channel identifier of the cell |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed |
| out_pass | output | 1 | Cell passes the filter |
| out_addr | output | 21 | Lookup table byte address, 0 on discard |

## Verification
The bench builds the block with its default widths: 8-bit path, 16-bit channel, 15-bit index and 21-bit address. With these widths, all 256 combinations of the two bit counts can be swept. Each combination is checked against the error flag. Every legal combination also carries cells whose addresses are computed arithmetically, and a base near the top of the address space brings the modulo wrap into reach. Every single path mask bit is toggled in both directions, and the channel comparison is broken in one bit. The backpressure test presents a second header while the first result is held, then checks that both results come out in order.

// File: rtl/vcf_pkg.sv
package vcf_pkg;

    parameter int VPI_W       = 8;
    parameter int VCI_W       = 16;
    parameter int PTR_W       = 15;
    parameter int ENTRY_SHIFT = 2;
    parameter int ADDR_W      = 21;
    parameter int NCNT_W      = 5;
    parameter int MCNT_W      = 3;
    parameter int REG_W       = 16;
    parameter int RIDX_W      = 3;
    parameter int MIN_SUM     = 8;
    parameter int MAX_SUM     = PTR_W;

    localparam int SUM_W     = NCNT_W + 1;
    localparam int OFF_W     = PTR_W + ENTRY_SHIFT;
    localparam int BASE_HI_W = ADDR_W - REG_W;

    typedef enum logic [RIDX_W-1:0] {
        REG_JOIN     = 3'd0,
        REG_VPI_CMP  = 3'd1,
        REG_VPI_MSK  = 3'd2,
        REG_VCI_CMP  = 3'd3,
        REG_BASE_LO  = 3'd4,
        REG_BASE_HI  = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic [NCNT_W-1:0] n_vci;
        logic [MCNT_W-1:0] m_vpi;
        logic [VPI_W-1:0]  vpi_cmp;
        logic [VPI_W-1:0]  vpi_msk;
        logic [VCI_W-1:0]  vci_cmp;
        logic [ADDR_W-1:0] base;
    } cfg_t;

    typedef struct packed {
        logic              pass;
        logic [ADDR_W-1:0] addr;
    } result_t;

    function automatic logic sum_bad(input logic [NCNT_W-1:0] n,
                                     input logic [MCNT_W-1:0] m);
        logic [SUM_W-1:0] s;
        s = SUM_W'(n) + SUM_W'(m);
        return (s < SUM_W'(MIN_SUM)) || (s > SUM_W'(MAX_SUM));
    endfunction

endpackage

// File: rtl/vcf_cfg_regs.sv
module vcf_cfg_regs
    import vcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RIDX_W-1:0] idx,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output cfg_t              cfg,
    output logic              bad_cfg
);

    logic spare_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            spare_q <= 1'b0;
        end else if (we) begin
            case (idx)
                REG_JOIN: begin
                    cfg.n_vci <= wdata[NCNT_W-1:0];
                    cfg.m_vpi <= wdata[NCNT_W+MCNT_W-1:NCNT_W];
                    spare_q   <= wdata[NCNT_W+MCNT_W];
                end
                REG_VPI_CMP: cfg.vpi_cmp <= wdata[VPI_W-1:0];
                REG_VPI_MSK: cfg.vpi_msk <= wdata[VPI_W-1:0];
                REG_VCI_CMP: cfg.vci_cmp <= wdata[VCI_W-1:0];
                REG_BASE_LO: cfg.base[REG_W-1:0] <= wdata;
                REG_BASE_HI: cfg.base[ADDR_W-1:REG_W] <= wdata[BASE_HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (idx)
            REG_JOIN:    rdata[NCNT_W+MCNT_W:0] = {spare_q, cfg.m_vpi, cfg.n_vci};
            REG_VPI_CMP: rdata[VPI_W-1:0]       = cfg.vpi_cmp;
            REG_VPI_MSK: rdata[VPI_W-1:0]       = cfg.vpi_msk;
            REG_VCI_CMP: rdata[VCI_W-1:0]       = cfg.vci_cmp;
            REG_BASE_LO: rdata                  = cfg.base[REG_W-1:0];
            REG_BASE_HI: rdata[BASE_HI_W-1:0]   = cfg.base[ADDR_W-1:REG_W];
            default:     rdata                  = '0;
        endcase
    end

    assign bad_cfg = sum_bad(cfg.n_vci, cfg.m_vpi);

endmodule

// File: rtl/vcf_hdr_match.sv
module vcf_hdr_match
    import vcf_pkg::*;
(
    input  logic [VPI_W-1:0] vpi,
    input  logic [VCI_W-1:0] vci,
    input  logic [VPI_W-1:0] vpi_cmp,
    input  logic [VPI_W-1:0] vpi_msk,
    input  logic [VCI_W-1:0] vci_cmp,
    output logic             hit
);

    logic [VPI_W-1:0] bit_ok;

    for (genvar b = 0; b < VPI_W; b++) begin : g_vpi_bit
        assign bit_ok[b] = !vpi_msk[b] || (vpi[b] == vpi_cmp[b]);
    end

    assign hit = (&bit_ok) && (vci == vci_cmp);

endmodule

// File: rtl/vcf_ptr_gen.sv
module vcf_ptr_gen
    import vcf_pkg::*;
(
    input  logic [VPI_W-1:0]  vpi,
    input  logic [VCI_W-1:0]  vci,
    input  logic [NCNT_W-1:0] n_vci,
    input  logic [MCNT_W-1:0] m_vpi,
    input  logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] addr
);

    localparam int WIDE = 32;

    logic [WIDE-1:0]   lo_part;
    logic [WIDE-1:0]   hi_part;
    logic [WIDE-1:0]   joined;
    logic [PTR_W-1:0]  ptr;
    logic [OFF_W-1:0]  offset;
    logic              unused_hi;

    always_comb begin
        lo_part = WIDE'(vci) & ((WIDE'(1) << n_vci) - WIDE'(1));
        hi_part = (WIDE'(vpi) & ((WIDE'(1) << m_vpi) - WIDE'(1))) << n_vci;
        joined  = lo_part | hi_part;
    end

    assign ptr       = joined[PTR_W-1:0];
    assign unused_hi = |joined[WIDE-1:PTR_W];
    assign offset    = {ptr, {ENTRY_SHIFT{1'b0}}};
    assign addr      = base + ADDR_W'(offset);

endmodule

// File: rtl/cell_vc_filter.sv
module cell_vc_filter
    import vcf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    output logic              cfg_err,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_vpi,
    input  logic [15:0]       in_vci,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_pass,
    output logic [20:0]       out_addr
);

    cfg_t              cfg;
    logic              hit;
    logic [ADDR_W-1:0] calc_addr;
    result_t           next_res;
    result_t           res_q;
    logic              take;

    vcf_cfg_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .idx     (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .cfg     (cfg),
        .bad_cfg (cfg_err)
    );

    vcf_hdr_match i_match (
        .vpi     (in_vpi),
        .vci     (in_vci),
        .vpi_cmp (cfg.vpi_cmp),
        .vpi_msk (cfg.vpi_msk),
        .vci_cmp (cfg.vci_cmp),
        .hit     (hit)
    );

    vcf_ptr_gen i_ptr (
        .vpi   (in_vpi),
        .vci   (in_vci),
        .n_vci (cfg.n_vci),
        .m_vpi (cfg.m_vpi),
        .base  (cfg.base),
        .addr  (calc_addr)
    );

    always_comb begin
        next_res.pass = hit && !cfg_err;
        next_res.addr = next_res.pass ? calc_addr : '0;
    end

    assign in_ready = !out_valid || out_ready;
    assign take     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            res_q     <= next_res;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign out_pass = res_q.pass;
    assign out_addr = res_q.addr;

endmodule

// File: rtl/vcf_checker.sv
module vcf_checker (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  cfg_addr,
    input logic [15:0] cfg_rdata,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_pass,
    input logic [20:0] out_addr
);

    // R10
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pass) && $stable(out_addr)));

    // R10
    no_take_when_held_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R9
    result_follows_take_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    // R7
    discard_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_pass) |-> (out_addr == 21'd0));

    // R2
    join_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == 3'd0) |-> (cfg_rdata[15:9] == 7'd0));

endmodule

bind cell_vc_filter vcf_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pass  (out_pass),
    .out_addr  (out_addr)
);

// File: tb/test_cell_vc_filter.sv
`timescale 1ns/1ps
module test_cell_vc_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        cfg_err;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_vpi = 8'd0;
    logic [15:0] in_vci = 16'd0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_pass;
    logic [20:0] out_addr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cell_vc_filter i_cell_vc_filter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .in_valid(in_valid), .in_ready(in_ready), .in_vpi(in_vpi), .in_vci(in_vci),
        .out_valid(out_valid), .out_ready(out_ready), .out_pass(out_pass),
        .out_addr(out_addr)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic wr(input int idx, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 3'(idx); cfg_wdata = 16'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input int idx, output int data);
        @(negedge clk);
        cfg_addr = 3'(idx);
        #1;
        data = int'(cfg_rdata);
    endtask

    // Sends one header with out_ready high; returns the result seen one edge later.
    task automatic send(input int vpi, input int vci, output int pass, output int addr);
        @(negedge clk);
        in_valid = 1'b1; in_vpi = 8'(vpi); in_vci = 16'(vci);
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (!out_valid) begin
            errors++;
            $display("FAIL R9 actual=out_valid 0 expected=1");
        end
        pass = int'(out_pass);
        addr = int'(out_addr);
    endtask

    function automatic int exp_addr(int n, int m, int vpi, int vci, int base);
        int ptr;
        ptr = ((vpi % (1 << m)) << n) + (vci % (1 << n));
        ptr = ptr % (1 << 15);
        return (base + ptr * 4) % (1 << 21);
    endfunction

    initial begin
        int v, p, a, base;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        #1;
        check("R1 out_valid", out_valid, 0);
        check("R1 in_ready", in_ready, 1);
        check("R8 cfg_err at reset", cfg_err, 1);
        for (int i = 0; i < 8; i++) begin
            rd(i, v);
            check("R1 reg reset", v, 0);
        end

        // R2 register layout and reserved bits
        wr(0, 16'hFFFF); rd(0, v); check("R2 join reg", v, 16'h01FF);
        wr(1, 16'hFFFF); rd(1, v); check("R2 vpi match", v, 16'h00FF);
        wr(2, 16'hFFFF); rd(2, v); check("R2 vpi mask", v, 16'h00FF);
        wr(3, 16'hBEEF); rd(3, v); check("R2 vci match", v, 16'hBEEF);
        wr(4, 16'h1234); rd(4, v); check("R2 base lo", v, 16'h1234);
        wr(5, 16'hFFFF); rd(5, v); check("R2 base hi", v, 16'h001F);
        wr(6, 16'hFFFF); rd(6, v); check("R2 idx6", v, 0);
        rd(7, v); check("R2 idx7", v, 0);

        // R3 R4 worked case
        wr(0, (4 << 5) | 8); wr(1, 0); wr(2, 0); wr(3, 16'h5678);
        wr(4, 0); wr(5, 0);
        send(8'h23, 16'h5678, p, a);
        check("R3 R4 example pass", p, 1);
        check("R3 R4 example addr", a, 21'h00DE0);

        // R8 R3 R4 sweep of all bit-count combinations
        base = 21'h1FF000;
        wr(4, base & 16'hFFFF); wr(5, base >> 16);
        for (int m = 0; m < 8; m++) begin
            for (int n = 0; n < 32; n++) begin
                int vci;
                bit bad;
                bad = (m + n < 8) || (m + n > 15);
                vci = (n * 1103 + m * 97 + 16'h5678) & 16'hFFFF;
                wr(0, (m << 5) | n);
                wr(3, vci);
                #1;
                check("R8 cfg_err", cfg_err, bad);
                if (bad) begin
                    send(8'hA5, vci, p, a);
                    check("R8 discard pass", p, 0);
                    check("R8 discard addr", a, 0);
                end else begin
                    for (int k = 0; k < 3; k++) begin
                        int vpi;
                        vpi = (k * 37 + m * 11 + n) & 8'hFF;
                        send(vpi, vci, p, a);
                        check("R3 sweep pass", p, 1);
                        check("R4 sweep addr", a, exp_addr(n, m, vpi, vci, base));
                    end
                end
            end
        end

        // R5 per-bit mask, R6 channel compare, R7 discard
        wr(0, (4 << 5) | 8); wr(4, 16'h0100); wr(5, 0);
        wr(1, 8'h5A); wr(3, 16'hC0DE);
        for (int b = 0; b < 8; b++) begin
            wr(2, 1 << b);
            send(8'h5A ^ (1 << b), 16'hC0DE, p, a);
            check("R5 masked bit differs", p, 0);
            check("R7 discard addr", a, 0);
            send((8'h5A ^ ~(1 << b)) & 8'hFF, 16'hC0DE, p, a);
            check("R5 unmasked bits ignored", p, 1);
            check("R4 mask addr", a,
                  exp_addr(8, 4, (8'h5A ^ ~(1 << b)) & 8'hFF, 16'hC0DE, 16'h0100));
        end
        wr(2, 0);
        send(8'h00, 16'hC0DE ^ 16'h8000, p, a);
        check("R6 vci top bit differs", p, 0);
        check("R7 vci discard addr", a, 0);
        send(8'h00, 16'hC0DE ^ 16'h0001, p, a);
        check("R6 vci low bit differs", p, 0);

        // R10 backpressure, R9 ordering
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_vpi = 8'h11; in_vci = 16'hC0DE;
        @(negedge clk);
        in_vpi = 8'h22;
        check("R9 first result valid", out_valid, 1);
        check("R10 in_ready low", in_ready, 0);
        a = int'(out_addr);
        check("R10 first addr", a, exp_addr(8, 4, 8'h11, 16'hC0DE, 16'h0100));
        @(negedge clk);
        check("R10 held addr", out_addr, a);
        check("R10 held pass", out_pass, 1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 second result valid", out_valid, 1);
        check("R10 second addr", out_addr, exp_addr(8, 4, 8'h22, 16'hC0DE, 16'h0100));
        @(negedge clk);
        check("R9 drained", out_valid, 0);

        finish_run();
    end

endmodule